// File: doc/BRIEF.md
# Load/Store Address Generator

This block works out, for a single-register load or store, the address that goes to memory and the value that goes back into the base register. Each request carries a base register value, an offset, an up/down control and a two-bit indexing mode. The offset comes either from a zero-extended 12-bit immediate or from a full-width register value that the shifter supplies.

Three indexing modes are supported. Plain offset mode accesses base plus or minus offset and leaves the base untouched. Pre-indexed mode accesses the same sum and also writes it back to the base. Post-indexed mode accesses the unmodified base and then writes the sum back. A single set of registers captures the results one cycle after a request. The pipeline uses them there to drive the memory port and the register-file write port.

Top module: `lsag_top`

## Requirements
- R1: Mode code 0 (plain offset): accAddr = base ± offset, wbEn = 0, and wbData carries the unmodified base.
- R2: Mode code 1 (pre-indexed): accAddr = base ± offset, wbData equals accAddr, and wbEn = 1.
- R3: Mode code 2 (post-indexed): accAddr = the unmodified base, wbData = base ± offset, and wbEn = 1.
- R4: upDown = 1 adds the offset and upDown = 0 subtracts it. The arithmetic is modulo 2^32, so a carry out or a borrow wraps.
- R5: useRegOfs = 0 selects the 12-bit immediate, zero-extended, and regOfs has no effect. useRegOfs = 1 selects the full 32-bit regOfs, and immOfs has no effect.
- R6: A zero offset gives accAddr equal to the base in every mode.
- R7: Results register one cycle after reqValid is high, and accValid is reqValid delayed by one cycle. A cycle with reqValid low leaves accAddr and wbData unchanged and forces wbEn to 0.
- R8: After reset, accValid, wbEn, accAddr and wbData are all 0.
- R9: Mode code 3 behaves as plain offset mode. It accesses base ± offset and does not write back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| modeSel | input | 2 | Indexing mode: 0 offset, 1 pre-indexed, 2 post-indexed, 3 treated as offset |
| upDown | input | 1 | 1 adds the offset, 0 subtracts it |
| useRegOfs | input | 1 | 1 selects regOfs, 0 selects immOfs |
| baseVal | input | 32 | Base register value |
| immOfs | input | 12 | Unsigned immediate offset |
| regOfs | input | 32 | Register offset from the shifter |
| accValid | output | 1 | Registered results are valid |
| accAddr | output | 32 | Memory access address |
| wbData | output | 32 | Value for the base register |
| wbEn | output | 1 | Base register writeback enable |

## Verification
Every result of this block is due exactly one clock edge after the request that produces it, and this holds for all three indexing modes. The bench applies inputs on the falling edge and keeps a behavioural model of the next register state. On the following falling edge it compares all four outputs against that model. Idle cycles are mixed in, so the hold behaviour and the forced-low writeback enable are checked in the same cycle-by-cycle comparison.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

  typedef enum logic [1:0] {
    MODE_OFFSET = 2'd0,
    MODE_PRE_WB = 2'd1,
    MODE_POST   = 2'd2,
    MODE_RSVD   = 2'd3
  } lsMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;         // capture a new request
    logic addrFromSum;  // address is base +/- offset (else raw base)
    logic wbEnable;     // request writes the base back
    logic subtract;     // offset is subtracted
    logic selReg;       // offset taken from the register path
  } ctlStrobes_t;

endpackage

// File: rtl/lsag_ctrl.sv
module lsag_ctrl
  import lsag_pkg::*;
(
  input  logic        reqValid,
  input  logic [1:0]  modeSel,
  input  logic        upDown,
  input  logic        useRegOfs,
  output ctlStrobes_t strobes
);

  lsMode_e modeDec;

  always_comb begin
    modeDec = lsMode_e'(modeSel);
    strobes.load     = reqValid;
    strobes.subtract = ~upDown;
    strobes.selReg   = useRegOfs;
    case (modeDec)
      MODE_OFFSET: begin strobes.addrFromSum = 1'b1; strobes.wbEnable = 1'b0; end
      MODE_PRE_WB: begin strobes.addrFromSum = 1'b1; strobes.wbEnable = 1'b1; end
      MODE_POST:   begin strobes.addrFromSum = 1'b0; strobes.wbEnable = 1'b1; end
      default:     begin strobes.addrFromSum = 1'b1; strobes.wbEnable = 1'b0; end
    endcase
  end

endmodule

// File: rtl/lsag_datapath.sv
module lsag_datapath
  import lsag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [IMM_W-1:0]  immOfs,
  input  logic [ADDR_W-1:0] regOfs,
  output logic              accValid,
  output logic [ADDR_W-1:0] accAddr,
  output logic [ADDR_W-1:0] wbData,
  output logic              wbEn
);

  localparam int PAD_W = (ADDR_W > IMM_W) ? ADDR_W - IMM_W : 1;

  logic [ADDR_W-1:0] immExt;
  logic [ADDR_W-1:0] ofsSel;
  logic [ADDR_W-1:0] addend;
  logic [ADDR_W-1:0] carryIn;
  logic [ADDR_W-1:0] sum;

  generate
    if (ADDR_W > IMM_W) begin : gPad
      assign immExt = {{PAD_W{1'b0}}, immOfs};
    end else begin : gTrunc
      assign immExt = immOfs[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    ofsSel  = strobes.selReg ? regOfs : immExt;
    addend  = strobes.subtract ? ~ofsSel : ofsSel;
    carryIn = {{(ADDR_W-1){1'b0}}, strobes.subtract};
    sum     = baseVal + addend + carryIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accValid <= 1'b0;
      accAddr  <= '0;
      wbData   <= '0;
      wbEn     <= 1'b0;
    end else begin
      accValid <= strobes.load;
      if (strobes.load) begin
        accAddr <= strobes.addrFromSum ? sum : baseVal;
        wbData  <= strobes.wbEnable ? sum : baseVal;
        wbEn    <= strobes.wbEnable;
      end else begin
        wbEn    <= 1'b0;
      end
    end
  end

  AST_WB_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> accValid); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> ($stable(accAddr) && $stable(wbData) && !wbEn)); // R7

  AST_POST_RAW_BASE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !strobes.addrFromSum) |=> (accAddr == $past(baseVal))); // R3

endmodule

// File: rtl/lsag_top.sv
module lsag_top
  import lsag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        modeSel,
  input  logic              upDown,
  input  logic              useRegOfs,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [IMM_W-1:0]  immOfs,
  input  logic [ADDR_W-1:0] regOfs,
  output logic              accValid,
  output logic [ADDR_W-1:0] accAddr,
  output logic [ADDR_W-1:0] wbData,
  output logic              wbEn
);

  ctlStrobes_t strobes;

  lsag_ctrl uCtrl (
    .reqValid  (reqValid),
    .modeSel   (modeSel),
    .upDown    (upDown),
    .useRegOfs (useRegOfs),
    .strobes   (strobes)
  );

  lsag_datapath #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .baseVal  (baseVal),
    .immOfs   (immOfs),
    .regOfs   (regOfs),
    .accValid (accValid),
    .accAddr  (accAddr),
    .wbData   (wbData),
    .wbEn     (wbEn)
  );

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> accValid); // R7

  AST_OFFSET_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && modeSel == 2'd0) |=> (!wbEn && wbData == $past(baseVal))); // R1

  AST_RSVD_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && modeSel == 2'd3) |=> !wbEn); // R9

  AST_PRE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && modeSel == 2'd1) |=> (wbEn && accAddr == wbData)); // R2

  AST_ZERO_OFS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !useRegOfs && immOfs == '0) |=> (accAddr == $past(baseVal))); // R6

endmodule

// File: tb/lsag_top_test.sv
module lsag_top_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic upDown = 1'b1;
  logic useRegOfs = 1'b0;
  logic [31:0] baseVal = '0;
  logic [11:0] immOfs = '0;
  logic [31:0] regOfs = '0;
  logic accValid, wbEn;
  logic [31:0] accAddr, wbData;

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  // behavioural model of the registered state
  logic        mValid = 0, mWbEn = 0;
  logic [31:0] mAddr = 0, mWb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsag_top uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .modeSel(modeSel),
    .upDown(upDown), .useRegOfs(useRegOfs), .baseVal(baseVal),
    .immOfs(immOfs), .regOfs(regOfs), .accValid(accValid),
    .accAddr(accAddr), .wbData(wbData), .wbEn(wbEn)
  );

  task automatic cmp(string tag, string what, logic [31:0] got, logic [31:0] exp);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s %s: got %08h expected %08h", tag, what, got, exp);
    end
  endtask

  task automatic compareAll(string tag);
    cmp(tag, "accValid", {31'b0, accValid}, {31'b0, mValid});
    cmp(tag, "accAddr", accAddr, mAddr);
    cmp(tag, "wbData", wbData, mWb);
    cmp(tag, "wbEn", {31'b0, wbEn}, {31'b0, mWbEn});
  endtask

  // apply one cycle of stimulus (called at a falling edge), check at the next
  task automatic step(bit v, int md, bit up, bit useReg, logic [31:0] b,
                      logic [11:0] imm, logic [31:0] ro, string tag);
    logic [31:0] ofs, s;
    reqValid = v; modeSel = md[1:0]; upDown = up; useRegOfs = useReg;
    baseVal = b; immOfs = imm; regOfs = ro;
    ofs = useReg ? ro : {20'b0, imm};
    s = up ? b + ofs : b - ofs;
    mValid = v;
    if (v) begin
      case (md)
        1: begin mAddr = s; mWb = s; mWbEn = 1; end
        2: begin mAddr = b; mWb = s; mWbEn = 1; end
        default: begin mAddr = s; mWb = b; mWbEn = 0; end
      endcase
    end else begin
      mWbEn = 0;
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compareAll("R8");                      // reset state
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R8");
    // R1 plain offset
    step(1, 0, 1, 0, 32'h0009_0000, 12'd4, 32'h0, "R1");
    // R2 pre-indexed with writeback
    step(1, 1, 1, 0, 32'h0009_0000, 12'd4, 32'h0, "R2");
    // R3 post-indexed
    step(1, 2, 1, 0, 32'h0009_0000, 12'd4, 32'h0, "R3");
    // R4 subtract and wrap both ways
    step(1, 1, 0, 0, 32'h0000_2010, 12'd16, 32'h0, "R4");
    step(1, 0, 1, 1, 32'hFFFF_FFF0, 12'd0, 32'h0000_0020, "R4");
    step(1, 2, 0, 0, 32'h0000_0000, 12'd1, 32'h0, "R4");
    // R5 offset source selection, unused source must not matter
    step(1, 0, 1, 0, 32'h0000_1000, 12'hFFF, 32'hDEAD_BEEF, "R5");
    step(1, 0, 1, 1, 32'h0000_1000, 12'h123, 32'h0001_0000, "R5");
    // R6 zero offset in every mode
    for (int m = 0; m < 4; m++) step(1, m, 0, 0, 32'h1234_5678, 12'd0, 32'hFFFF_FFFF, "R6");
    // R7 idle cycles: hold addresses, drop writeback
    step(1, 1, 1, 0, 32'h0000_4000, 12'd8, 32'h0, "R7");
    step(0, 1, 1, 0, 32'h5555_0000, 12'd9, 32'h0, "R7");
    step(0, 2, 0, 1, 32'hAAAA_0000, 12'd1, 32'h77, "R7");
    // R9 reserved mode code
    step(1, 3, 1, 0, 32'h0009_0000, 12'd4, 32'h0, "R9");
    step(1, 3, 0, 1, 32'h0009_0000, 12'd4, 32'h100, "R9");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      automatic int md = $urandom_range(0, 3);
      automatic string tg = (md == 1) ? "R2" : (md == 2) ? "R3" : (md == 3) ? "R9" : "R1";
      step($urandom_range(0, 3) != 0, md, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, $urandom, 12'($urandom), $urandom, tg);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule